// File: doc/BRIEF.md
# Fast-Mode Parallel Bus Cycle Generator

This block turns a parallel printer port into a small external bus for a peripheral with its own register set. The host has three standard register addresses at `BASE_ADDR`. Five more addresses sit directly above them. An access to one of these extra offsets starts a complete bus cycle on the port pins without any software handshaking. A write to offset 3 puts a register address on the data lines and strobes it with the address strobe. A read or a write to offsets 4 to 7 strobes the data strobe and moves one byte. The write line shows the direction, and on a read the data lines are released so the peripheral can drive them.

The peripheral can stretch any cycle by holding its active-low wait line. Wait passes through a two-flop synchronizer. Each strobe stays low for a programmable minimum number of clocks before wait is honoured. The host side is a request/ready pair: the host holds `host_req` until it sees a single-cycle `host_ready`, and read data is returned on `host_rdata`. When fast mode is off, the three shared control pins and the data lines simply carry the standard printer-port values given on the `std_*` inputs.

Top module: `fastbus_gen`

## Requirements
- R1: With `fast_en` high, a host write to offset 3 runs an address cycle. `addr_strb_n` goes low while `data_strb_n` and `write_n` stay high, and `pd_oe` is 1 with the write byte on `pd_o`.
- R2: With `fast_en` high, a host write to offsets 4 to 7 runs a data write cycle. `data_strb_n` goes low, `write_n` is low, and `pd_oe` is 1 with the write byte on `pd_o`.
- R3: With `fast_en` high, a host read of offsets 4 to 7 runs a data read cycle. `data_strb_n` goes low, `write_n` is high and `pd_oe` is 0. The byte on `pd_i` at the clock edge that ends the strobe appears on `host_rdata` by the time `host_ready` is 1.
- R4: A strobe stays low for at least M clocks, where M is `min_low_cyc`, and a value of 0 counts as 1. With wait inactive it stays low for exactly M clocks.
- R5: `wait_n` passes through two flip-flops. The strobe ends on the first clock at which it has been low for at least M clocks and the synchronized wait is high. Suppose the peripheral pulls `wait_n` low within the first strobe cycle and releases it W cycles later. Then the strobe lasts max(M, W+3) clocks when M is 3 or more, and M clocks when M is 1 or 2.
- R6: `host_ready` is a one-cycle pulse that comes one clock after the strobe returns high. The host must hold `host_req` and its address, direction and data until it sees the pulse, and drop `host_req` in that same cycle.
- R7: Data lines and write line are set up one clock before the strobe falls and held for one clock after it rises.
- R8: With `fast_en` low, no access starts a cycle and `host_ready` stays 0. `addr_strb_n`, `data_strb_n`, `write_n`, `pd_o` and `pd_oe` equal `std_a_n`, `std_d_n`, `std_w_n`, `std_data` and `std_data_oe`. Clearing `fast_en` also aborts a running cycle.
- R9: With `fast_en` high, accesses to offsets 0 to 2, offsets above 7, addresses below the base, and reads of offset 3 start no cycle and get no `host_ready`.
- R10: During and after reset with `fast_en` high and no cycle running, both strobes and `write_n` are 1, `pd_oe` is 0 and `host_ready` is 0.
- R11: `irq_o` is `irq_i` delayed by two flip-flops while `fast_en` is high, and 0 while `fast_en` is low.
- R12: The address strobe and the data strobe are never low at the same time in fast mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_en | input | 1 | Enables the extra addresses and bus-cycle pin use |
| host_req | input | 1 | Host access request, held until ready |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Host I/O address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte captured on a data read |
| host_ready | output | 1 | One-cycle completion pulse |
| min_low_cyc | input | CNT_W | Minimum strobe low time in clocks (0 = 1) |
| std_a_n | input | 1 | Standard control value for the address-strobe pin |
| std_d_n | input | 1 | Standard control value for the data-strobe pin |
| std_w_n | input | 1 | Standard control value for the write pin |
| std_data | input | 8 | Standard data register value |
| std_data_oe | input | 1 | Standard data output enable |
| addr_strb_n | output | 1 | Address strobe pin, active low |
| data_strb_n | output | 1 | Data strobe pin, active low |
| write_n | output | 1 | Write line, active low |
| pd_o | output | 8 | Data lines, outgoing value |
| pd_oe | output | 1 | Data line drive enable |
| pd_i | input | 8 | Data lines, incoming value |
| wait_n | input | 1 | Peripheral wait, active low, asynchronous |
| irq_i | input | 1 | Peripheral interrupt request, asynchronous |
| irq_o | output | 1 | Synchronized interrupt request |

## Verification
A sequencer stuck in a strobe state shows at once at the ports. The strobe pin stays low and no ready pulse arrives, so the host access times out within a few dozen clocks. A miscounted minimum or a wait synchronizer that is too short or too long shows as a strobe width that differs from max(M, W+3) by one or more clocks on the very first stretched cycle. A wrong direction or cycle kind shows during the strobe itself: the wrong strobe, the write line in the wrong state, or the data lines driven during a read. A wrong capture point shows in the next ready cycle as a read byte that does not match the peripheral model's contents.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_STRB,
    S_REL,
    S_ACK
  } fbc_state_t;

  typedef enum logic [1:0] {
    K_ADDR,
    K_WR,
    K_RD
  } cyc_kind_t;

  // minimum strobe width with zero treated as one
  function automatic int unsigned eff_min(int unsigned m);
    return (m == 0) ? 1 : m;
  endfunction

  // true once cnt+1 low cycles satisfy the minimum
  function automatic logic min_met(int unsigned cnt, int unsigned m);
    return (cnt + 1) >= eff_min(m);
  endfunction

endpackage

// File: rtl/fbc_sync.sv
module fbc_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= RST_VAL;
      q  <= RST_VAL;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/fbc_seq.sv
module fbc_seq
  import fbc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             start,
  input  cyc_kind_t        start_kind,
  input  logic [7:0]       start_data,
  input  logic [CNT_W-1:0] min_cyc,
  input  logic             wait_ok,
  input  logic [7:0]       bus_in,
  output logic             astb_act,
  output logic             dstb_act,
  output logic             wr_act,
  output logic             drv_act,
  output logic [7:0]       bus_out,
  output logic [7:0]       rdata,
  output logic             ready,
  output logic             release_evt
);
  fbc_state_t       state;
  cyc_kind_t        kind;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lat_min;
  logic             in_cyc;
  logic             width_ok;

  assign width_ok    = min_met(32'(cnt), 32'(lat_min));
  assign release_evt = (state == S_STRB) && width_ok && wait_ok;
  assign in_cyc      = (state == S_SETUP) || (state == S_STRB) || (state == S_REL);
  assign astb_act    = (state == S_STRB) && (kind == K_ADDR);
  assign dstb_act    = (state == S_STRB) && (kind != K_ADDR);
  assign wr_act      = in_cyc && (kind == K_WR);
  assign drv_act     = in_cyc && (kind != K_RD);
  assign ready       = (state == S_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      kind    <= K_ADDR;
      cnt     <= '0;
      lat_min <= '0;
      bus_out <= '0;
      rdata   <= '0;
    end else if (abort) begin
      state <= S_IDLE;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          kind    <= start_kind;
          bus_out <= start_data;
          lat_min <= min_cyc;
          state   <= S_SETUP;
        end
        S_SETUP: begin
          cnt   <= '0;
          state <= S_STRB;
        end
        S_STRB: begin
          if (!width_ok) begin
            cnt <= cnt + 1'b1;
          end else if (wait_ok) begin
            if (kind == K_RD) rdata <= bus_in;
            state <= S_REL;
          end
        end
        S_REL:   state <= S_ACK;
        S_ACK:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R6
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
endmodule

// File: rtl/fastbus_gen.sv
module fastbus_gen
  import fbc_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F8,
  parameter int              CNT_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_en,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              host_ready,
  input  logic [CNT_W-1:0]  min_low_cyc,
  input  logic              std_a_n,
  input  logic              std_d_n,
  input  logic              std_w_n,
  input  logic [7:0]        std_data,
  input  logic              std_data_oe,
  output logic              addr_strb_n,
  output logic              data_strb_n,
  output logic              write_n,
  output logic [7:0]        pd_o,
  output logic              pd_oe,
  input  logic [7:0]        pd_i,
  input  logic              wait_n,
  input  logic              irq_i,
  output logic              irq_o
);
  localparam int RUN_W = CNT_W + 2;

  // offset of the host address from the port base (wraps below base)
  function automatic logic [ADDR_W-1:0] port_off(logic [ADDR_W-1:0] a);
    return a - BASE_ADDR;
  endfunction

  logic [ADDR_W-1:0] off;
  logic              is_ext;
  logic              accept;
  cyc_kind_t         req_kind;
  logic [1:0]        sync_q;
  logic              wait_ok;
  logic              irq_s;
  logic              astb_act, dstb_act, wr_act, drv_act, release_evt;
  logic [7:0]        bus_out;
  logic              strb_act;

  assign off      = port_off(host_addr);
  assign is_ext   = (off >= ADDR_W'(3)) && (off <= ADDR_W'(7));
  assign accept   = fast_en && host_req && is_ext && !((off == ADDR_W'(3)) && !host_wr);
  assign req_kind = (off == ADDR_W'(3)) ? K_ADDR : (host_wr ? K_WR : K_RD);

  fbc_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({irq_i, wait_n}),
    .q     (sync_q)
  );
  assign wait_ok = sync_q[0];
  assign irq_s   = sync_q[1];

  fbc_seq #(.CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .abort       (!fast_en),
    .start       (accept),
    .start_kind  (req_kind),
    .start_data  (host_wdata),
    .min_cyc     (min_low_cyc),
    .wait_ok     (wait_ok),
    .bus_in      (pd_i),
    .astb_act    (astb_act),
    .dstb_act    (dstb_act),
    .wr_act      (wr_act),
    .drv_act     (drv_act),
    .bus_out     (bus_out),
    .rdata       (host_rdata),
    .ready       (host_ready),
    .release_evt (release_evt)
  );

  assign strb_act    = astb_act || dstb_act;
  assign addr_strb_n = fast_en ? !astb_act : std_a_n;
  assign data_strb_n = fast_en ? !dstb_act : std_d_n;
  assign write_n     = fast_en ? !wr_act   : std_w_n;
  assign pd_oe       = fast_en ? drv_act   : std_data_oe;
  assign pd_o        = fast_en ? bus_out   : std_data;
  assign irq_o       = fast_en && irq_s;

  // independent strobe-run counter for the width check
  logic [RUN_W-1:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= '0;
    else if (!strb_act) low_run <= '0;
    else if (low_run != {RUN_W{1'b1}}) low_run <= low_run + 1'b1;
  end

  // R12
  strb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fast_en |-> (addr_strb_n || data_strb_n));

  // R1
  addr_wr_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_en && !addr_strb_n) |-> (write_n && pd_oe));

  // R3
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_en && !data_strb_n && write_n) |-> !pd_oe);

  // R4
  min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(strb_act) && $past(fast_en)) |->
      (32'(low_run) >= eff_min(32'(min_low_cyc))));

  // R5
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(strb_act) && $past(fast_en)) |-> $past(wait_ok));

  // R6
  ready_after_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> (!$past(strb_act) && $past(strb_act, 2)));

  // R8
  disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_en |=> !host_ready);
endmodule

// File: tb/fastbus_gen_test.sv
module fastbus_gen_test;
  localparam logic [15:0] BASE = 16'h03F8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fast_en = 1'b1;
  logic        host_req = 1'b0;
  logic        host_wr = 1'b0;
  logic [15:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        host_ready;
  logic [3:0]  min_low_cyc = 4'd3;
  logic        std_a_n = 1'b1, std_d_n = 1'b1, std_w_n = 1'b1;
  logic [7:0]  std_data = '0;
  logic        std_data_oe = 1'b0;
  logic        addr_strb_n, data_strb_n, write_n, pd_oe;
  logic [7:0]  pd_o, pd_i;
  logic        wait_n = 1'b1;
  logic        irq_i = 1'b0;
  logic        irq_o;

  always #4 clk = ~clk;

  fastbus_gen uut (
    .clk(clk), .rst_n(rst_n), .fast_en(fast_en),
    .host_req(host_req), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ready(host_ready),
    .min_low_cyc(min_low_cyc),
    .std_a_n(std_a_n), .std_d_n(std_d_n), .std_w_n(std_w_n),
    .std_data(std_data), .std_data_oe(std_data_oe),
    .addr_strb_n(addr_strb_n), .data_strb_n(data_strb_n), .write_n(write_n),
    .pd_o(pd_o), .pd_oe(pd_oe), .pd_i(pd_i),
    .wait_n(wait_n), .irq_i(irq_i), .irq_o(irq_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard item: kind 0=address, 1=data write, 2=data read
  typedef struct {
    int       kind;
    bit [7:0] data;
    int       width;
  } item_t;
  item_t exp_q[$];

  // peripheral model
  logic [7:0] pmem [256];
  logic [7:0] paddr = '0;
  int         wait_len = 0;
  int         wrem = 0;
  assign pd_i = pmem[paddr];

  // host-side expectation model
  logic [7:0] m_mem [256];
  logic [7:0] m_addr = '0;

  initial begin
    for (int i = 0; i < 256; i++) begin
      pmem[i]  = 8'(i * 7 + 3);
      m_mem[i] = 8'(i * 7 + 3);
    end
  end

  function automatic int exp_width(input int m, input int w);
    int e;
    e = (m == 0) ? 1 : m;
    if (w == 0 || e <= 2) return e;
    return (e > w + 3) ? e : w + 3;
  endfunction

  // monitor + peripheral, sampling at the falling edge
  bit       p_low = 0, p2_low = 0, p_wr_n = 1, p_oe = 0, p_rdy = 0;
  int       run = 0;
  bit [7:0] cap = '0;
  always @(negedge clk) begin
    bit now_low;
    now_low = fast_en && (!addr_strb_n || !data_strb_n);
    if (wrem > 0) begin
      wrem--;
      if (wrem == 0) wait_n = 1'b1;
    end
    if (fast_en && rst_n) begin
      if (now_low && !p_low) begin
        run = 1;
        cap = pd_o;
        if (wait_len > 0) begin wait_n = 1'b0; wrem = wait_len; end
        if (exp_q.size() == 0) begin
          check(0, "R12 unexpected strobe", 1, 0);
        end else begin
          // R7 setup: lines already valid the cycle before the fall
          check(p_wr_n == (exp_q[0].kind != 1), "R7 write setup", p_wr_n, exp_q[0].kind != 1);
          check(p_oe == (exp_q[0].kind != 2), "R7 data setup", p_oe, exp_q[0].kind != 2);
          if (exp_q[0].kind == 0) begin
            // R1
            check(!addr_strb_n && data_strb_n && write_n && pd_oe && pd_o == exp_q[0].data,
                  "R1 address cycle", {addr_strb_n, data_strb_n, write_n, pd_oe, pd_o},
                  {4'b0111, exp_q[0].data});
          end else if (exp_q[0].kind == 1) begin
            // R2
            check(addr_strb_n && !data_strb_n && !write_n && pd_oe && pd_o == exp_q[0].data,
                  "R2 data write", {addr_strb_n, data_strb_n, write_n, pd_oe, pd_o},
                  {4'b1001, exp_q[0].data});
          end else begin
            // R3
            check(addr_strb_n && !data_strb_n && write_n && !pd_oe,
                  "R3 data read pins", {addr_strb_n, data_strb_n, write_n, pd_oe}, 4'b1010);
          end
        end
      end else if (now_low) begin
        run++;
      end else if (p_low && exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        // R4 / R5
        check(run == it.width, "R4/R5 strobe width", run, it.width);
        // R7 hold
        check(write_n == (it.kind != 1) && pd_oe == (it.kind != 2), "R7 hold after rise",
              {write_n, pd_oe}, {it.kind != 1, it.kind != 2});
        if (it.kind == 0) paddr = cap;
        else begin
          if (it.kind == 1) pmem[paddr] = cap;
          paddr = paddr + 1'b1;
        end
      end
      if (host_ready) begin
        // R6
        check(!p_low && p2_low && !p_rdy, "R6 ready timing", {p_low, p2_low, p_rdy}, 3'b010);
      end
    end
    p2_low = p_low;
    p_low  = now_low;
    p_wr_n = write_n;
    p_oe   = pd_oe;
    p_rdy  = host_ready;
  end

  // driver: pushes the expected bus cycle then runs the host handshake
  task automatic do_acc(input int off, input bit wr, input bit [7:0] d, input int wlen);
    item_t it;
    bit [7:0] exp_rd;
    int n;
    it.kind  = (off == 3) ? 0 : (wr ? 1 : 2);
    it.data  = d;
    it.width = exp_width(int'(min_low_cyc), wlen);
    exp_rd   = '0;
    if (it.kind == 0) m_addr = d;
    else begin
      if (it.kind == 1) m_mem[m_addr] = d;
      else exp_rd = m_mem[m_addr];
      m_addr = m_addr + 1'b1;
    end
    exp_q.push_back(it);
    @(negedge clk);
    wait_len   = wlen;
    host_addr  = BASE + 16'(off);
    host_wr    = wr;
    host_wdata = d;
    host_req   = 1'b1;
    n = 0;
    while (!host_ready && n < 100) begin
      @(negedge clk);
      n++;
    end
    check(host_ready, "R6 ready arrives", host_ready, 1);
    host_req = 1'b0;
    if (it.kind == 2) check(host_rdata == exp_rd, "R3 read data", host_rdata, exp_rd);
    wait_len = 0;
  endtask

  // an access that must start nothing
  task automatic try_ignored(input int off, input bit wr, input string req);
    bit seen;
    seen = 0;
    @(negedge clk);
    host_addr  = BASE + 16'(off);
    host_wr    = wr;
    host_wdata = 8'h5A;
    host_req   = 1'b1;
    repeat (12) begin
      @(negedge clk);
      if (host_ready || (fast_en && (!addr_strb_n || !data_strb_n))) seen = 1;
    end
    host_req = 1'b0;
    check(!seen, req, seen, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R10 reset state
    check(addr_strb_n && data_strb_n && write_n && !pd_oe && !host_ready,
          "R10 during reset", {addr_strb_n, data_strb_n, write_n, pd_oe, host_ready}, 5'b11100);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(addr_strb_n && data_strb_n && write_n && !pd_oe && !host_ready,
          "R10 idle after reset", {addr_strb_n, data_strb_n, write_n, pd_oe, host_ready}, 5'b11100);

    min_low_cyc = 4'd3;
    do_acc(3, 1, 8'h10, 0);   // R1
    do_acc(4, 1, 8'hA5, 0);   // R2
    do_acc(7, 1, 8'h3C, 0);   // R2
    do_acc(3, 1, 8'h10, 0);
    do_acc(5, 0, 8'h00, 0);   // R3 read back A5
    do_acc(6, 0, 8'h00, 4);   // R3 + R5 width 7
    min_low_cyc = 4'd5;
    do_acc(4, 1, 8'hC3, 2);   // R5 max(5,5)
    do_acc(4, 1, 8'h96, 6);   // R5 width 9
    do_acc(5, 0, 8'h00, 1);
    min_low_cyc = 4'd0;
    do_acc(4, 1, 8'h01, 0);   // R4 zero counts as one
    do_acc(3, 1, 8'h40, 0);
    do_acc(6, 0, 8'h00, 0);
    min_low_cyc = 4'd2;
    do_acc(4, 0, 8'h00, 3);   // R5 wait missed below three
    min_low_cyc = 4'd15;
    do_acc(7, 1, 8'hFF, 0);   // R4 long minimum
    min_low_cyc = 4'd4;

    // R9 ignored offsets in fast mode
    try_ignored(0, 1, "R9 offset 0 write");
    try_ignored(2, 0, "R9 offset 2 read");
    try_ignored(3, 0, "R9 offset 3 read");
    try_ignored(8, 1, "R9 offset 8 write");
    try_ignored(-1, 1, "R9 below base");

    // R8 fast mode off
    fast_en = 1'b0;
    try_ignored(4, 1, "R8 write ignored when off");
    std_a_n = 1'b0; std_d_n = 1'b1; std_w_n = 1'b0; std_data = 8'h6E; std_data_oe = 1'b1;
    @(negedge clk);
    check({addr_strb_n, data_strb_n, write_n, pd_oe, pd_o} == {4'b0101, 8'h6E},
          "R8 std pass pattern 1", {addr_strb_n, data_strb_n, write_n, pd_oe, pd_o}, {4'b0101, 8'h6E});
    std_a_n = 1'b1; std_d_n = 1'b0; std_w_n = 1'b1; std_data = 8'h91; std_data_oe = 1'b0;
    @(negedge clk);
    check({addr_strb_n, data_strb_n, write_n, pd_oe, pd_o} == {4'b1010, 8'h91},
          "R8 std pass pattern 2", {addr_strb_n, data_strb_n, write_n, pd_oe, pd_o}, {4'b1010, 8'h91});
    std_d_n = 1'b1;
    // R11 irq gated off
    irq_i = 1'b1;
    repeat (3) @(negedge clk);
    check(irq_o == 1'b0, "R11 irq gated when off", irq_o, 0);
    irq_i = 1'b0;
    repeat (3) @(negedge clk);
    fast_en = 1'b1;
    // R8 the ignored write did not reach the peripheral: read continues from model
    do_acc(3, 1, 8'h10, 0);
    do_acc(4, 0, 8'h00, 0);
    // R11 two-flop delay
    @(negedge clk);
    irq_i = 1'b1;
    @(negedge clk);
    check(irq_o == 1'b0, "R11 irq after one edge", irq_o, 0);
    @(negedge clk);
    check(irq_o == 1'b1, "R11 irq after two edges", irq_o, 1);
    irq_i = 1'b0;
    repeat (3) @(negedge clk);
    check(irq_o == 1'b0, "R11 irq falls", irq_o, 0);

    check(exp_q.size() == 0, "R12 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule